// File: doc/BRIEF.md
# Byte-stuffed IPMI message framer

This block serialises one outgoing message, held in a byte buffer owned by a neighbouring register block, into a framed byte stream for a virtual IPMI serial link. A start pulse arms a transfer. The block then reads the buffer through its address and data pins and puts the bytes out on a valid/ready stream. Buffer slot 0 holds the length, so it is not sent. The next two header bytes leave in swapped order. A negated-sum checksum follows the payload, and an end-of-message marker closes the frame. Any byte that collides with one of the three reserved marker values is sent as a two-byte escape pair.

When the link is reported open, the same stream carries a short announcement instead: the version command, the protocol version number and an end-of-command marker. The buffer is read combinationally. The neighbour must keep the buffer contents unchanged while `busy_o` is high.

Top module: `frame_stuffer`

## Requirements
- R1: After reset `out_valid_o` and `busy_o` are low.
- R2: For a buffer length L (slot 0 holds L, 2 <= L <= BUF_DEPTH), slots 1 to L-1 are sent in order with slot 0 left out. When L >= 3, slot 2 is sent before slot 1. When L = 2, only slot 1 is sent.
- R3: A payload or checksum byte equal to 0xA0, 0xA1 or 0xAA is sent as 0xAA followed by that byte ORed with 0x10. All other bytes are sent unchanged.
- R4: After the payload comes the 8-bit two's complement of the sum of the payload bytes as sent (after the swap, before escaping). This byte is escaped under R3.
- R5: Every message ends with a single unescaped 0xA0. A length of 0 or 1 produces the checksum 0x00 followed by 0xA0.
- R6: A pulse on `link_open_i` while idle emits 0xFF, 0x01, 0xA1. If it arrives in the same cycle as `start_i`, the announcement wins and the start is dropped.
- R7: While `out_valid_o` is high and `out_ready_i` is low, `out_data_o` and `out_valid_o` hold their values.
- R8: `busy_o` rises in the cycle after an accepted start and falls in the cycle after the final marker is accepted. `start_i` and `link_open_i` have no effect while busy.
- R9: A full buffer of BUF_DEPTH slots is framed completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse: frame the buffer contents |
| link_open_i | input | 1 | Pulse: emit the version announcement |
| len_i | input | LW | Buffer length, sampled with `start_i` |
| rd_addr_o | output | AW | Buffer slot being read |
| rd_data_i | input | 8 | Combinational buffer read data |
| out_valid_o | output | 1 | Stream byte valid |
| out_data_o | output | 8 | Stream byte |
| out_ready_i | input | 1 | Sink accepts the byte |
| busy_o | output | 1 | A frame or announcement is in flight |

## Verification
The bench targets payloads that contain every reserved value, including one that is chosen so the checksum itself must be escaped. A design that escaped only the payload would send a raw marker in that case and cut the frame short on the receiving side. Short buffers of length 0, 1 and 2 check that the swap is not applied to slots past the end, and that an empty frame still carries its zero checksum. A start pulse sent in mid-frame, and one sent together with a link-open pulse, would show up as stray stream bytes if the block did not ignore it. A random ready pattern also exposes a byte that changes while it is stalled.

// File: rtl/frame_stuffer.sv
module frame_stuffer #(
  parameter int BUF_DEPTH = 64,
  localparam int AW = $clog2(BUF_DEPTH),
  localparam int LW = $clog2(BUF_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          link_open_i,
  input  logic [LW-1:0] len_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic          out_valid_o,
  output logic [7:0]    out_data_o,
  input  logic          out_ready_i,
  output logic          busy_o
);

  localparam logic [7:0] MSG_END = 8'hA0;
  localparam logic [7:0] CMD_END = 8'hA1;
  localparam logic [7:0] ESC     = 8'hAA;

  typedef enum logic [2:0] {S_IDLE, S_DATA, S_SUM, S_END, S_VER, S_PVER, S_CEND} st_t;

  st_t           st;
  logic [AW-1:0] idx;
  logic [LW-1:0] len_q;
  logic [7:0]    sum;
  logic          second;
  logic [7:0]    raw;
  logic          need_esc, fire, advance, last;

  always_comb begin
    case (st)
      S_DATA:  raw = rd_data_i;
      S_SUM:   raw = 8'h00 - sum;
      S_END:   raw = MSG_END;
      S_VER:   raw = 8'hFF;
      S_PVER:  raw = 8'h01;
      S_CEND:  raw = CMD_END;
      default: raw = 8'h00;
    endcase
  end

  assign need_esc    = (st == S_DATA || st == S_SUM) &&
                       (raw == MSG_END || raw == CMD_END || raw == ESC);
  assign out_valid_o = (st != S_IDLE);
  assign busy_o      = out_valid_o;
  assign out_data_o  = second ? (raw | 8'h10) : (need_esc ? ESC : raw);
  assign fire        = out_valid_o && out_ready_i;
  assign advance     = fire && (second || !need_esc);
  assign last        = (LW'(idx) == len_q - LW'(1));

  always_comb begin
    rd_addr_o = idx;
    if (len_q >= LW'(3)) begin
      if (idx == AW'(1))      rd_addr_o = AW'(2);
      else if (idx == AW'(2)) rd_addr_o = AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= '0;
      len_q  <= '0;
      sum    <= '0;
      second <= 1'b0;
    end else if (st == S_IDLE) begin
      second <= 1'b0;
      sum    <= '0;
      if (link_open_i) begin
        st <= S_VER;
      end else if (start_i) begin
        len_q <= len_i;
        idx   <= AW'(1);
        st    <= (len_i <= LW'(1)) ? S_SUM : S_DATA;
      end
    end else if (fire) begin
      if (!advance) begin
        second <= 1'b1;
      end else begin
        second <= 1'b0;
        case (st)
          S_DATA: begin
            sum <= sum + raw;
            if (last) st <= S_SUM;
            else      idx <= idx + AW'(1);
          end
          S_SUM:   st <= S_END;
          S_END:   st <= S_IDLE;
          S_VER:   st <= S_PVER;
          S_PVER:  st <= S_CEND;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))); // R7

  AST_ESC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_data_o == ESC) |=> (out_valid_o &&
      (out_data_o == 8'hB0 || out_data_o == 8'hB1 || out_data_o == 8'hBA))); // R3

  AST_MSG_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_data_o == MSG_END) |=> !busy_o); // R5

  AST_CMD_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_data_o == CMD_END) |=> !busy_o); // R6

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !fire) |=> busy_o); // R8

endmodule

// File: tb/test_frame_stuffer.sv
module test_frame_stuffer;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, start = 0, lopen = 0, ready = 1, valid, busy;
  logic [LW-1:0] len = '0;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data, odata;
  logic [7:0] mem [DEPTH];
  byte unsigned q[$];
  int checks = 0, errors = 0, ready_mode = 0, cycles = 0;
  string cur = "R1";

  always #2 clk = ~clk;
  assign rd_data = mem[rd_addr];

  frame_stuffer #(.BUF_DEPTH(DEPTH)) i_frame_stuffer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .link_open_i(lopen), .len_i(len),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .out_valid_o(valid), .out_data_o(odata),
    .out_ready_i(ready), .busy_o(busy));

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    ready <= (ready_mode == 0) ? 1'b1 : ($urandom % 3 != 0);
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && valid) begin
      if (q.size() == 0) chk(0, cur, odata, -1);
      else begin
        chk(odata == q[0], cur, odata, q[0]);
        if (ready) void'(q.pop_front());
      end
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic push_esc(byte unsigned b);
    if (b == 8'hA0 || b == 8'hA1 || b == 8'hAA) begin
      q.push_back(8'hAA);
      q.push_back(b | 8'h10);
    end else q.push_back(b);
  endtask

  task automatic build(int n);
    byte unsigned s = 0;
    for (int i = 1; i < n; i++) begin
      int a = (n >= 3 && i == 1) ? 2 : (n >= 3 && i == 2) ? 1 : i;
      s += mem[a];
      push_esc(mem[a]);
    end
    push_esc(8'h00 - s);
    q.push_back(8'hA0);
  endtask

  task automatic send(int n, string req);
    cur = req;
    @(negedge clk);
    len = LW'(n);
    mem[0] = 8'(n);
    build(n);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R8", busy, 1);
  endtask

  task automatic drain(string req);
    while (q.size() != 0 || busy) @(negedge clk);
    chk(busy == 0 && valid == 0, req, busy, 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'(i * 7 + 3);
    #1;
    chk(valid == 0 && busy == 0, "R1", {valid, busy}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(valid == 0 && busy == 0, "R1", {valid, busy}, 0);

    cur = "R6";
    q.push_back(8'hFF); q.push_back(8'h01); q.push_back(8'hA1);
    lopen = 1; @(negedge clk); lopen = 0;
    drain("R6");

    mem[1] = 8'h18; mem[2] = 8'h05; mem[3] = 8'h01; mem[4] = 8'h42;
    send(5, "R2"); drain("R2");

    mem[1] = 8'hA0; mem[2] = 8'hA1; mem[3] = 8'hAA; mem[4] = 8'h10;
    send(5, "R3"); drain("R3");

    begin
      byte unsigned s;
      mem[1] = 8'h2C; mem[2] = 8'h11; mem[3] = 8'h3B;
      s = mem[1] + mem[2] + mem[3];
      mem[4] = 8'h56 - s;
      send(5, "R4"); drain("R4");
      mem[4] = 8'h5F - s;
      send(5, "R4"); drain("R4");
    end

    send(0, "R5"); drain("R5");
    send(1, "R5"); drain("R5");
    mem[1] = 8'h77; mem[2] = 8'h99;
    send(2, "R2"); drain("R2");

    ready_mode = 1;
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'(i * 13 + 160);
    send(9, "R7"); drain("R7");

    send(6, "R8");
    repeat (2) @(negedge clk);
    len = LW'(3); start = 1; lopen = 1;
    @(negedge clk);
    start = 0; lopen = 0;
    drain("R8");
    repeat (4) begin @(negedge clk); chk(valid == 0, "R8", valid, 0); end

    cur = "R6";
    q.push_back(8'hFF); q.push_back(8'h01); q.push_back(8'hA1);
    len = LW'(4); start = 1; lopen = 1;
    @(negedge clk);
    start = 0; lopen = 0;
    drain("R6");
    repeat (3) begin @(negedge clk); chk(valid == 0, "R6", valid, 0); end

    for (int i = 1; i < DEPTH; i++) mem[i] = 8'(i * 29 + 1);
    send(DEPTH, "R9"); drain("R9");
    ready_mode = 0;
    send(DEPTH, "R9"); drain("R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule